// File: doc/BRIEF.md
# Handshaked Protection Challenge Unit

This block is a small bank of 16-bit registers that a host uses to confirm that a security coprocessor is fitted and to pull challenge words out of it. The coprocessor is modelled inside the block. Its answers come from a fixed four-entry lookup, and its response time comes from two down-counters. No real cryptography is performed.

The host first reads the presence flag in the status/start register. It then stores a seed value and writes the init command. It polls until the init-complete flag is set. For each challenge word, the host writes an index and writes the fetch command to the fetch register. It polls the ready flag and then reads the result register. Every step must come in this order. A fetch issued before initialisation has finished never completes.

The block has only a single-cycle write strobe with address and data, plus a combinational read port.

Top module: `prot_challenge_regs`

## Requirements
- R1: After reset, the status/start register (0x14) reads 0x0001, where bit 0 is the always-set presence flag. The seed (0x0C), index (0x0E), result (0x10) and fetch (0x12) registers read 0x0000.
- R2: A write to 0x0C stores the full 16-bit seed, and reading 0x0C returns it.
- R3: Writing 0x0003 to 0x14 clears the init-complete flag (bit 2) and sets the init-busy flag (bit 1). Exactly 16 clock edges after the write edge, bit 2 reads 1 and bit 1 reads 0. Any other value written to 0x14 has no effect.
- R4: After initialisation, writing 0x0001 to 0x12 clears the ready flag (bit 1 of 0x12) and sets the fetch-busy flag (bit 0). Exactly 8 clock edges after the write edge, bit 1 reads 1 and bit 0 reads 0.
- R5: When ready sets, the result register 0x10 holds the word for the current index: index 0 gives 0x1F9F, 1 gives 0x1F03, 2 gives 0x1F1C and 3 gives 0x1F57.
- R6: A completed fetch with an index greater than 3 leaves 0x0000 in the result register.
- R7: A fetch command written while the init-complete flag is 0 never sets the ready flag, and 0x12 reads 0x0000 afterwards.
- R8: Writing the index register (0x0E) clears the ready flag at once and cancels any pending fetch. The result register keeps its previous value.
- R9: Any value other than 0x0001 written to 0x12 has no effect.
- R10: A read of any address other than the five registers returns 0x0000.
- R11: Starting a new initialisation also clears the ready flag and cancels any pending fetch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | 8 | Byte address of the register |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |

## Verification
A corrupted latency counter shows up as the ready or init-complete flag rising one or more cycles early or late. For this reason the bench samples these flags on the cycle before the expected edge and on the cycle of it. A wrong lookup entry or a lost index shows up in the result word on the first poll after ready rises. A state machine that lets a fetch through without initialisation, or keeps a stale ready flag after an index write or a re-initialisation, is visible on the next read of the fetch register. The bound checker flags such cases on the very next clock edge.

// File: rtl/prot_challenge_regs.sv
module prot_challenge_regs #(
  parameter int ADDR_W    = 8,
  parameter int INIT_LAT  = 16,
  parameter int FETCH_LAT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata
);
  localparam logic [ADDR_W-1:0] A_SEED  = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] A_INDEX = ADDR_W'(8'h0E);
  localparam logic [ADDR_W-1:0] A_DATA  = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(8'h12);
  localparam logic [ADDR_W-1:0] A_INIT  = ADDR_W'(8'h14);
  localparam logic [15:0] CMD_FETCH = 16'h0001;
  localparam logic [15:0] CMD_INIT  = 16'h0003;
  localparam int MAX_LAT = (INIT_LAT > FETCH_LAT) ? INIT_LAT : FETCH_LAT;
  localparam int CW = $clog2(MAX_LAT + 1);

  logic [15:0] seed_q, index_q, data_q;
  logic        init_busy, init_done, fetch_busy, fetch_rdy;
  logic [CW-1:0] init_cnt, fetch_cnt;

  wire start_init  = wr_en && addr == A_INIT && wdata == CMD_INIT;
  wire start_fetch = wr_en && addr == A_CTRL && wdata == CMD_FETCH;
  wire wr_index    = wr_en && addr == A_INDEX;

  function automatic logic [15:0] lookup(input logic [15:0] idx);
    case (idx)
      16'd0:   return 16'h1F9F;
      16'd1:   return 16'h1F03;
      16'd2:   return 16'h1F1C;
      16'd3:   return 16'h1F57;
      default: return 16'h0000;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seed_q <= '0;
    else if (wr_en && addr == A_SEED) seed_q <= wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_busy <= 1'b0;
      init_done <= 1'b0;
      init_cnt  <= '0;
    end else if (start_init) begin
      init_busy <= 1'b1;
      init_done <= 1'b0;
      init_cnt  <= CW'(INIT_LAT - 1);
    end else if (init_busy) begin
      if (init_cnt == '0) begin
        init_busy <= 1'b0;
        init_done <= 1'b1;
      end else begin
        init_cnt <= init_cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      index_q    <= '0;
      data_q     <= '0;
      fetch_busy <= 1'b0;
      fetch_rdy  <= 1'b0;
      fetch_cnt  <= '0;
    end else if (wr_index) begin
      index_q    <= wdata;
      fetch_busy <= 1'b0;
      fetch_rdy  <= 1'b0;
    end else if (start_init) begin
      fetch_busy <= 1'b0;
      fetch_rdy  <= 1'b0;
    end else if (start_fetch) begin
      fetch_rdy  <= 1'b0;
      fetch_busy <= init_done;
      fetch_cnt  <= CW'(FETCH_LAT - 1);
    end else if (fetch_busy) begin
      if (fetch_cnt == '0) begin
        fetch_busy <= 1'b0;
        fetch_rdy  <= 1'b1;
        data_q     <= lookup(index_q);
      end else begin
        fetch_cnt <= fetch_cnt - 1'b1;
      end
    end
  end

  always_comb
    case (addr)
      A_SEED:  rdata = seed_q;
      A_INDEX: rdata = index_q;
      A_DATA:  rdata = data_q;
      A_CTRL:  rdata = {14'd0, fetch_rdy, fetch_busy};
      A_INIT:  rdata = {13'd0, init_done, init_busy, 1'b1};
      default: rdata = 16'h0000;
    endcase
endmodule

module prot_challenge_chk #(parameter int ADDR_W = 8) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [15:0]       wdata,
  input logic [15:0]       rdata,
  input logic              ready,
  input logic              done
);
  p_ready_needs_init_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> done);
  p_index_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(8'h0E)) |=> !ready);
  p_fetch_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(8'h12) && wdata == 16'h0001) |=> !ready);
  p_init_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(8'h14) && wdata == 16'h0003) |=> (!done && !ready));
  p_present_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(8'h14)) |-> rdata[0]);
  p_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(8'h00) || addr == ADDR_W'(8'h16)) |-> rdata == 16'h0000);
endmodule

bind prot_challenge_regs prot_challenge_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .ready(fetch_rdy), .done(init_done));

// File: tb/prot_challenge_regs_tb.sv
module prot_challenge_regs_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [7:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  prot_challenge_regs dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata));

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd(8'h14, v); check("R1 status", v, 16'h0001);
    rd(8'h0C, v); check("R1 seed", v, 16'h0000);
    rd(8'h0E, v); check("R1 index", v, 16'h0000);
    rd(8'h10, v); check("R1 result", v, 16'h0000);
    rd(8'h12, v); check("R1 fetch", v, 16'h0000);
  endtask

  task automatic t_unmapped;
    logic [15:0] v;
    rd(8'h02, v); check("R10 addr 02", v, 16'h0000);
    rd(8'h16, v); check("R10 addr 16", v, 16'h0000);
  endtask

  task automatic t_early_fetch;
    logic [15:0] v;
    wr(8'h0E, 16'd1);
    wr(8'h12, 16'h0001);
    cyc(20);
    rd(8'h12, v); check("R7 fetch before init", v, 16'h0000);
  endtask

  task automatic t_seed;
    logic [15:0] v;
    wr(8'h0C, 16'hA5C3);
    rd(8'h0C, v); check("R2 seed readback", v, 16'hA5C3);
  endtask

  task automatic t_init;
    logic [15:0] v;
    wr(8'h14, 16'h0002);
    cyc(20);
    rd(8'h14, v); check("R3 other value ignored", v, 16'h0001);
    wr(8'h14, 16'h0003);
    rd(8'h14, v); check("R3 busy after start", v, 16'h0003);
    cyc(15);
    rd(8'h14, v); check("R3 not done at 15", v, 16'h0003);
    cyc(1);
    rd(8'h14, v); check("R3 done at 16", v, 16'h0005);
  endtask

  task automatic t_fetch(input logic [15:0] idx, input logic [15:0] exp, input string req);
    logic [15:0] v;
    wr(8'h0E, idx);
    wr(8'h12, 16'h0001);
    rd(8'h12, v); check("R4 busy after start", v, 16'h0001);
    cyc(7);
    rd(8'h12, v); check("R4 not ready at 7", v, 16'h0001);
    cyc(1);
    rd(8'h12, v); check("R4 ready at 8", v, 16'h0002);
    rd(8'h10, v); check(req, v, exp);
  endtask

  task automatic t_ctl_ignore;
    logic [15:0] v;
    wr(8'h12, 16'h0002);
    cyc(10);
    rd(8'h12, v); check("R9 fetch write ignored", v, 16'h0002);
    rd(8'h10, v); check("R9 result kept", v, 16'h1F57);
  endtask

  task automatic t_index_clear;
    logic [15:0] v;
    wr(8'h0E, 16'd0);
    rd(8'h12, v); check("R8 ready cleared", v, 16'h0000);
    rd(8'h10, v); check("R8 result kept", v, 16'h1F57);
    wr(8'h12, 16'h0001);
    cyc(3);
    wr(8'h0E, 16'd1);
    cyc(12);
    rd(8'h12, v); check("R8 fetch aborted", v, 16'h0000);
    rd(8'h10, v); check("R8 result after abort", v, 16'h1F57);
  endtask

  task automatic t_reinit;
    logic [15:0] v;
    wr(8'h12, 16'h0001);
    cyc(10);
    rd(8'h12, v); check("R11 ready before reinit", v, 16'h0002);
    wr(8'h14, 16'h0003);
    rd(8'h12, v); check("R11 ready cleared", v, 16'h0000);
    cyc(20);
    rd(8'h12, v); check("R11 stays clear", v, 16'h0000);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_unmapped();
    t_early_fetch();
    t_seed();
    t_init();
    t_fetch(16'd0, 16'h1F9F, "R5 index 0");
    t_fetch(16'd1, 16'h1F03, "R5 index 1");
    t_fetch(16'd2, 16'h1F1C, "R5 index 2");
    t_fetch(16'd5, 16'h0000, "R6 index 5");
    t_fetch(16'd3, 16'h1F57, "R5 index 3");
    t_ctl_ignore();
    t_index_clear();
    t_reinit();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule